// File: doc/BRIEF.md
# Multiplexed External Code Fetch Interface

This block takes code-byte fetch requests from a CPU fetch unit and returns one byte per request. A mode strap, sampled when each request is accepted, picks the source. When the strap is high the byte comes from a small on-chip ROM model. When the strap is low every byte comes from an external program memory, reached over a narrow multiplexed bus.

That bus has a shared 8-bit port that carries the low address byte first and then the returned code byte. It also has an 8-bit port for the high address byte and two strobes. One is an address latch enable, which an external latch uses to capture the low byte. The other is an active-low program store enable, which the memory uses to drive its output. The shared port is modelled as separate output, output-enable and input signals.

The block runs a fixed phase sequence on the bus for each external fetch. During internal fetches the strobes and both ports are left idle, free for general-purpose use.

Top module: `code_fetch_if`

## Requirements
- R1: With `int_sel` high at acceptance, `rsp_data` equals the ROM byte at index `req_addr[7:0]`, whose content is `(index*29 + 0x4B) mod 256`. `rsp_valid` rises on the first clock edge after the accepting edge.
- R2: With `int_sel` low at acceptance, the ROM is not used. `rsp_data` is the value on `ad_in` at the edge where `psen_n` returns high. `rsp_valid` rises on the fourth clock edge after the accepting edge.
- R3: During an external fetch, `ahi_out` carries `req_addr[15:8]` with `ahi_oe` high from the cycle after acceptance until the response. `ad_out` carries `req_addr[7:0]` while `ale` is high. The full 16-bit space is reachable, including address 0000h.
- R4: `ale` is high for exactly one cycle per external fetch, and only while `ad_oe` and `ahi_oe` are high.
- R5: `ale` falls at least one cycle before `ad_oe` is released. `ad_oe` is high for exactly two cycles per external fetch.
- R6: `psen_n` is low for exactly two cycles per external fetch, and `ad_oe` is low throughout.
- R7: During an internal fetch, `ale` stays low, `psen_n` stays high, and `ad_oe` and `ahi_oe` stay low.
- R8: `rsp_valid` is a single-cycle pulse. `req_ready` is low from acceptance until the response cycle. A request presented while `req_ready` is low is ignored.
- R9: While `rst` is high, the block drives `ale`=0, `psen_n`=1, `ad_oe`=0, `ahi_oe`=0 and `rsp_valid`=0, and `req_ready` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_sel | input | 1 | Mode strap: 1 internal ROM, 0 external memory |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 16 | Code address |
| req_ready | output | 1 | Block idle, request will be accepted |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Fetched code byte |
| ad_out | output | 8 | Shared port output value (low address) |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value (code byte) |
| ahi_out | output | 8 | High address byte |
| ahi_oe | output | 1 | High address port enable |
| ale | output | 1 | Address latch enable strobe |
| psen_n | output | 1 | Active-low program store enable |

## Verification
The bench models an external latch that captures on `ale` and a memory that drives `ad_in` only while `psen_n` is low. If the design released the port before `ale` fell, or sampled the data too early, the latched address or the byte read back would be wrong. The bench sweeps many high/low address pairs, including 0000h and FFFFh, and every ROM index plus aliasing addresses. It counts strobe and enable cycles for each fetch, so a stretched or missing phase shows up as a wrong count or a wrong latency. Requests held while the block is busy, and strobe activity during internal fetches, are both checked at the ports.

// File: rtl/xfetch_pkg.sv
package xfetch_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_FLOAT,
    PH_SAMP
  } xphase_e;
endpackage

// File: rtl/code_rom.sv
module code_rom #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int MUL     = 29,
  parameter int ADD     = 8'h4B
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * MUL + ADD);
  end

  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xfetch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic          done,
  output logic [DW-1:0] data,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [HW-1:0] ahi_out,
  output logic          ahi_oe,
  output logic          ale,
  output logic          psen_n
);
  xphase_e ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ahi_out <= '0;
      ahi_oe  <= 1'b0;
      ale     <= 1'b0;
      psen_n  <= 1'b1;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph      <= PH_ADDR;
          ad_out  <= addr[DW-1:0];
          ad_oe   <= 1'b1;
          ahi_out <= addr[AW-1:DW];
          ahi_oe  <= 1'b1;
          ale     <= 1'b1;
        end
        PH_ADDR: begin
          ph  <= PH_HOLD;
          ale <= 1'b0;
        end
        PH_HOLD: begin
          ph     <= PH_FLOAT;
          ad_oe  <= 1'b0;
          psen_n <= 1'b0;
        end
        PH_FLOAT: ph <= PH_SAMP;
        PH_SAMP: begin
          ph     <= PH_IDLE;
          psen_n <= 1'b1;
          ahi_oe <= 1'b0;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign done = (ph == PH_SAMP);
  assign data = ad_in;

  assert_ale_addr_R4: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && ahi_oe));
  assert_ale_before_float_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe) |-> !$past(ale));
  assert_read_float_R6: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (!ad_oe && ahi_oe && !ale));
endmodule

// File: rtl/code_fetch_if.sv
module code_fetch_if #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   ahi_out,
  output logic              ahi_oe,
  output logic              ale,
  output logic              psen_n
);
  logic busy, ipend, accept, x_done;
  logic [DATA_W-1:0] rom_q, x_data;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;

  code_rom #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
    .clk  (clk),
    .en   (accept && int_sel),
    .addr (req_addr[ROM_AW-1:0]),
    .q    (rom_q)
  );

  xbus_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept && !int_sel),
    .addr    (req_addr),
    .done    (x_done),
    .data    (x_data),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ad_in   (ad_in),
    .ahi_out (ahi_out),
    .ahi_oe  (ahi_oe),
    .ale     (ale),
    .psen_n  (psen_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ipend     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ipend || x_done;
      if (ipend)       rsp_data <= rom_q;
      else if (x_done) rsp_data <= x_data;
      ipend <= accept && int_sel;
      if (accept)                busy <= 1'b1;
      else if (ipend || x_done)  busy <= 1'b0;
    end
  end

  assert_int_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ipend |-> (psen_n && !ale && !ad_oe && !ahi_oe));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !ipend && !x_done) |=> !req_ready);
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (psen_n && !ale && !ad_oe && !rsp_valid && req_ready));
endmodule

// File: tb/tb_code_fetch_if.sv
module tb_code_fetch_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_sel = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, ad_oe, ahi_oe, ale, psen_n;
  logic [7:0] rsp_data, ad_out, ad_in, ahi_out;
  logic [7:0] lat = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  code_fetch_if dut (
    .clk(clk), .rst(rst), .int_sel(int_sel), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ale(ale), .psen_n(psen_n)
  );

  function automatic logic [7:0] ext_byte(input logic [15:0] a);
    return a[15:8] ^ (a[7:0] * 8'd7 + 8'd3);
  endfunction

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return 8'(a[7:0] * 29 + 8'h4B);
  endfunction

  // external address latch and program memory
  always @(negedge clk) if (ale) lat <= ad_out;
  assign ad_in = !psen_n ? ext_byte({ahi_out, lat}) : 8'hC3;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a, input logic intl);
    int k, n_ale, n_oe, n_ps, n_act;
    bit addr_ok, hi_ok, ps_ok;
    @(negedge clk);
    int_sel = intl; req_addr = a; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; n_ale = 0; n_oe = 0; n_ps = 0; n_act = 0;
    addr_ok = 1; hi_ok = 1; ps_ok = 1;
    chk(!req_ready, "R8 busy", req_ready, 0);
    while (!rsp_valid && k < 20) begin
      if (ale) begin
        n_ale++;
        if (!(ad_oe && ahi_oe && ad_out == a[7:0])) addr_ok = 0;
      end
      if (ad_oe) n_oe++;
      if (!psen_n) begin
        n_ps++;
        if (ad_oe) ps_ok = 0;
      end
      if (ahi_oe && ahi_out != a[15:8]) hi_ok = 0;
      if (ale || !psen_n || ad_oe || ahi_oe) n_act++;
      @(negedge clk);
      k++;
    end
    if (intl) begin
      chk(k == 1, "R1 latency", k, 1);
      chk(rsp_data == rom_byte(a), "R1 data", rsp_data, rom_byte(a));
      chk(n_act == 0, "R7 quiet", n_act, 0);
    end else begin
      chk(k == 4, "R2 latency", k, 4);
      chk(rsp_data == ext_byte(a), "R2 data", rsp_data, ext_byte(a));
      chk(hi_ok && addr_ok && lat == a[7:0], "R3 address", {ahi_out, lat}, a);
      chk(n_ale == 1, "R4 ale cycles", n_ale, 1);
      chk(n_oe == 2, "R5 oe cycles", n_oe, 2);
      chk(n_ps == 2 && ps_ok, "R6 psen cycles", n_ps, 2);
    end
    chk(req_ready && psen_n && !ale, "R8 idle at rsp", req_ready, 1);
    @(negedge clk);
    chk(!rsp_valid, "R8 pulse", rsp_valid, 0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && !ad_oe && !ahi_oe && !rsp_valid && req_ready,
        "R9 reset", {ale, psen_n, ad_oe, ahi_oe, rsp_valid, req_ready}, 6'b010001);
    rst = 1'b0;
    fetch(16'h0000, 1'b0);  // R3 first fetch at 0000h
    fetch(16'hFFFF, 1'b0);
    for (int h = 0; h < 256; h += 17)
      for (int l = 0; l < 256; l += 3)
        fetch(16'(h * 256 + l), 1'b0);
    for (int i = 0; i < 256; i++) fetch(16'(i), 1'b1);
    for (int i = 0; i < 16; i++) fetch(16'(i * 4099 + 256), 1'b1);  // alias R1
    // R8: second request while busy is ignored
    @(negedge clk);
    int_sel = 1'b0; req_addr = 16'h1234; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 16'hABCD;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int seen = 0;
      logic [7:0] got = '0;
      for (int c = 0; c < 12; c++) begin
        if (rsp_valid) begin seen++; got = rsp_data; end
        @(negedge clk);
      end
      chk(seen == 1, "R8 ignored request", seen, 1);
      chk(got == ext_byte(16'h1234), "R8 data", got, ext_byte(16'h1234));
    end
    // mode switch back to back
    fetch(16'h0042, 1'b1);
    fetch(16'h0042, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule